// File: doc/BRIEF.md
# Paced Conversion Sampler with Sample Queue and Transfer Request

This block is the control side of an analog converter. Once `run` is high, it starts conversions at a steady pace. Each result goes into a small first-in first-out sample queue. A transfer-request line asks a DMA engine to drain the queue. The analog part is a stub with a fixed latency. At the end of each conversion it hands back whatever 12-bit value and error flag sit on its inputs.

The pacing divider sets the gap between conversion starts. A conversion cannot begin while another is still in flight. A zero divider therefore gives back-to-back conversions. Each stored word either keeps the full 12-bit result with the error flag, or keeps only the top 8 bits of the result.

The request line compares the queue level against a programmable threshold. A consumer pops one word per cycle of `rd_en`. The consumer must be armed before `run` is raised.

Top module: `sample_pacer`

## Requirements
- R1: After reset, `level` is 0, `overflow` is 0 and `dreq` is 0.
- R2: While `run` is low, no conversion starts and `level` stays 0.
- R3: Suppose `run` is set in a cycle with no conversion in flight. That result enters the queue CONV_LAT+1 clock edges later. After that, results arrive every max(`clkdiv`+1, CONV_LAT) edges.
- R4: With `clkdiv` = 0, conversions run back to back, one result every CONV_LAT edges.
- R5: With `shift8` = 0, a stored word holds the 12-bit result in bits 11:0 and the error flag in bit 15. All other bits are 0.
- R6: With `shift8` = 1, a stored word holds result bits 11:4 in bits 7:0. All other bits are 0, so the error flag is dropped.
- R7: While `fifo_en` is 0, results are discarded and `level` does not change from pushes.
- R8: The queue holds DEPTH (4) words. `rd_data` always shows the oldest word, and words leave in the order they arrived.
- R9: A result that arrives while the queue is full and no pop happens is dropped. The stored words are unchanged, and `overflow` goes to 1 and stays there until reset.
- R10: `dreq` is 1 exactly when `dreq_en` is 1 and `level` is at least max(`dreq_thresh`, 1).
- R11: A cycle with `rd_en` high and `level` > 0 removes one word. `level` and `dreq` change after that clock edge, not before it. `rd_en` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the pacer and the converter |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Allows new conversions to start |
| clkdiv | input | DIV_W | Pacing divider; starts are clkdiv+1 clocks apart |
| fifo_en | input | 1 | Lets results be written to the queue |
| dreq_en | input | 1 | Enables the transfer-request output |
| dreq_thresh | input | LVL_W | Queue level at which the request is raised |
| shift8 | input | 1 | Store only the top 8 result bits |
| conv_value | input | RAW_W | Stub converter result |
| conv_err | input | 1 | Stub converter error flag |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | DATA_W | Oldest word in the queue |
| level | output | LVL_W | Number of words held |
| dreq | output | 1 | Transfer request to the DMA engine |
| overflow | output | 1 | Sticky flag: a result was dropped |

## Verification
The pacing is swept over dividers below, at and above the conversion length. For each one the bench times the first result and the next two results. This separates divider-bound timing from latency-bound timing, and it catches off-by-one errors in either counter. Word formatting is tried in both modes with the error flag set, which shows whether the error flag survives in the full-width mode and is dropped in the 8-bit mode. A run of distinct values that overfills the queue checks ordering, the dropped fifth result and the sticky flag in one pass. Pops at thresholds above, at and below the level separate the request's threshold logic from its timing.

// File: rtl/sample_pacer.sv
module sample_pacer #(
  parameter int DIV_W    = 16,
  parameter int CONV_LAT = 96,
  parameter int DEPTH    = 4,
  parameter int RAW_W    = 12,
  parameter int DATA_W   = 16,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LVL_W   = $clog2(DEPTH + 1),
  localparam int CNT_W   = $clog2(CONV_LAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  clkdiv,
  input  logic              fifo_en,
  input  logic              dreq_en,
  input  logic [LVL_W-1:0]  dreq_thresh,
  input  logic              shift8,
  input  logic [RAW_W-1:0]  conv_value,
  input  logic              conv_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              dreq,
  output logic              overflow
);
  logic [DIV_W-1:0]  pace_cnt;
  logic              busy;
  logic [CNT_W-1:0]  conv_cnt;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [DATA_W-1:0] word;

  wire done  = busy && conv_cnt == '0;
  wire start = run && pace_cnt == '0 && (!busy || done);
  wire full  = level == LVL_W'(DEPTH);
  wire pop   = rd_en && level != '0;
  wire push  = done && fifo_en && (!full || pop);
  wire drop  = done && fifo_en && full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pace_cnt <= '0;
      busy     <= 1'b0;
      conv_cnt <= '0;
    end else begin
      if (start) pace_cnt <= clkdiv;
      else if (pace_cnt != '0) pace_cnt <= pace_cnt - 1'b1;
      if (start) begin
        busy     <= 1'b1;
        conv_cnt <= CNT_W'(CONV_LAT - 1);
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        conv_cnt <= conv_cnt - 1'b1;
      end
    end
  end

  always_comb begin
    word = '0;
    if (shift8) word[7:0] = conv_value[RAW_W-1 -: 8];
    else begin
      word[RAW_W-1:0] = conv_value;
      word[DATA_W-1]  = conv_err;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop) level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
      if (drop) overflow <= 1'b1;
    end
  end

  assign rd_data = mem[rptr];
  assign dreq    = dreq_en && level != '0 && level >= dreq_thresh;
endmodule

// File: rtl/sample_pacer_chk.sv
module sample_pacer_chk #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             fifo_en,
  input logic             rd_en,
  input logic [LVL_W-1:0] level,
  input logic             overflow
);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow && !rd_en && level != LVL_W'(DEPTH) |=> !overflow);

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r7_no_push_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && !rd_en |=> $stable(level));

  a_r11_pop_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && level != '0 |=> level <= $past(level));

  a_r11_empty_pop_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && level == '0 |=> level <= LVL_W'(1));
endmodule

bind sample_pacer sample_pacer_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fifo_en(fifo_en), .rd_en(rd_en),
  .level(level), .overflow(overflow)
);

// File: tb/sample_pacer_bench.sv
module sample_pacer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [15:0] clkdiv = '0;
  logic fifo_en = 1'b0, dreq_en = 1'b0, shift8 = 1'b0, conv_err = 1'b0, rd_en = 1'b0;
  logic [2:0] dreq_thresh = 3'd1;
  logic [11:0] conv_value = '0;
  logic [15:0] rd_data;
  logic [2:0] level;
  logic dreq, overflow;

  int checks = 0, errors = 0, edges = 0, push_n = 0;
  int push_t [0:7];
  logic [2:0] prev_level = '0;

  sample_pacer #(.CONV_LAT(L)) u_sample_pacer (
    .clk(clk), .rst_n(rst_n), .run(run), .clkdiv(clkdiv), .fifo_en(fifo_en),
    .dreq_en(dreq_en), .dreq_thresh(dreq_thresh), .shift8(shift8),
    .conv_value(conv_value), .conv_err(conv_err), .rd_en(rd_en),
    .rd_data(rd_data), .level(level), .dreq(dreq), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      push_n = 0;
      prev_level = '0;
    end else begin
      if (level > prev_level && push_n < 8) begin
        push_t[push_n] = edges;
        push_n = push_n + 1;
      end
      prev_level = level;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 0; rd_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pop_one();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_pushes(input int n);
    while (push_n < n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int divs [6] = '{0, 3, 7, 8, 12, 20};
    dreq_en = 1; dreq_thresh = 1;
    do_reset();
    check(level == 0, "R1 level", int'(level), 0);
    check(overflow == 0, "R1 overflow", int'(overflow), 0);
    check(dreq == 0, "R1 dreq", int'(dreq), 0);

    fifo_en = 1;
    repeat (40) @(negedge clk);
    check(level == 0, "R2 idle without run", int'(level), 0);

    foreach (divs[i]) begin
      int c0, gap;
      do_reset();
      clkdiv = 16'(divs[i]); fifo_en = 1;
      c0 = edges;
      run = 1;
      wait_pushes(3);
      run = 0;
      gap = (divs[i] + 1 > L) ? divs[i] + 1 : L;
      check(push_t[0] - c0 == L + 1, "R3 first result latency", push_t[0] - c0, L + 1);
      check(push_t[1] - push_t[0] == gap, divs[i] == 0 ? "R4 back-to-back gap" : "R3 paced gap 1",
            push_t[1] - push_t[0], gap);
      check(push_t[2] - push_t[1] == gap, "R3 paced gap 2", push_t[2] - push_t[1], gap);
    end

    do_reset();
    clkdiv = 20; fifo_en = 1; shift8 = 0; conv_err = 1; conv_value = 12'hA5C;
    run = 1; wait_pushes(1); run = 0;
    check(rd_data == 16'h8A5C, "R5 full-width word", int'(rd_data), 16'h8A5C);
    pop_one();
    repeat (L + 2) @(negedge clk);
    shift8 = 1;
    run = 1; wait_pushes(2); run = 0;
    check(rd_data == 16'h00A5, "R6 shifted word", int'(rd_data), 16'h00A5);
    shift8 = 0; conv_err = 0;

    do_reset();
    fifo_en = 0; clkdiv = 0; run = 1;
    repeat (40) @(negedge clk);
    check(level == 0, "R7 writes disabled", int'(level), 0);
    fifo_en = 1;
    wait_pushes(1);
    run = 0;
    check(level == 1, "R7 writes re-enabled", int'(level), 1);

    do_reset();
    clkdiv = 20; fifo_en = 1; conv_value = 12'd1;
    run = 1;
    for (int k = 1; k <= 4; k++) begin
      wait_pushes(k);
      conv_value = 12'(k + 1);
    end
    while (!overflow && push_t[3] + 60 > edges) @(negedge clk);
    run = 0;
    check(overflow == 1, "R9 overflow set", int'(overflow), 1);
    check(level == 4, "R9 level held at depth", int'(level), 4);
    for (int k = 1; k <= 4; k++) begin
      check(rd_data == 16'(k), "R8 order", int'(rd_data), k);
      pop_one();
    end
    check(level == 0, "R8 drained", int'(level), 0);
    check(overflow == 1, "R9 overflow sticky", int'(overflow), 1);
    pop_one();
    check(level == 0, "R11 pop on empty", int'(level), 0);

    do_reset();
    clkdiv = 0; fifo_en = 1; dreq_en = 1; dreq_thresh = 3;
    run = 1; wait_pushes(4); run = 0;
    repeat (L + 2) @(negedge clk);
    check(level == 4, "R10 queue full", int'(level), 4);
    check(dreq == 1, "R10 dreq at level 4 thr 3", int'(dreq), 1);
    pop_one();
    check(level == 3 && dreq == 1, "R11 dreq after first pop", int'(dreq), 1);
    rd_en = 1;
    #1;
    check(dreq == 1, "R11 dreq unchanged before edge", int'(dreq), 1);
    @(negedge clk);
    rd_en = 0;
    check(level == 2 && dreq == 0, "R11 dreq drops after edge", int'(dreq), 0);
    dreq_thresh = 0; #1;
    check(dreq == 1, "R10 threshold 0 acts as 1", int'(dreq), 1);
    dreq_en = 0; #1;
    check(dreq == 0, "R10 dreq disabled", int'(dreq), 0);
    dreq_en = 1; dreq_thresh = 1;
    pop_one(); pop_one();
    check(level == 0 && dreq == 0, "R10 empty no dreq", int'(dreq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule